// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block moves one byte at a time over a three-wire synchronous serial link: a shift clock, a serial output and a serial input. Each transfer sends the loaded byte and captures a byte from the input line at the same time. A single start pulse begins a transfer. A busy level covers the transfer, and a sticky done flag, mirrored on an interrupt request line, marks its end.

The shift clock comes from one of two sources. It can be produced inside the block by dividing the system clock with one of six fixed ratios. It can also come from an external pin, which is first resynchronised into the system clock domain. Software picks the bit order (most or least significant bit first) and the sampling edge. Every setting is captured when a start is accepted, so changes made during a transfer do not disturb it.

Top module: `sio_shifter`

## Requirements
- R1: While and right after reset, busy, done and irq are 0, sck_out is 1 and ser_out is 1.
- R2: rate_sel picks the internal divide ratio: code 0 gives 512, 1 gives 256, 2 gives 128, 3 gives 32, 4 gives 16, 5 gives 8, and the unused codes 6 and 7 give 512. In internal mode, busy stays high for exactly 8 times the ratio system cycles after the accepting edge.
- R3: sck_out rests high whenever no internal transfer runs. An internal transfer makes exactly 8 low pulses on it, each half a ratio low and half a ratio high.
- R4: With lsb_first=1 the byte leaves bit 0 first and bit 7 last. With lsb_first=0 it leaves bit 7 first. The first bit is on ser_out from the cycle after the start is accepted.
- R5: With sample_rise=1, ser_in is sampled on rising shift-clock edges and ser_out advances on falling edges. With sample_rise=0 the two edges swap roles. A shifting edge that comes before the first sample does not move ser_out.
- R6: With ext_clk_sel=1, sck_in passes through a two-flop synchroniser and drives the transfer, sck_out stays high, and the transfer ends on the eighth sampling edge.
- R7: rx_byte keeps the bit order of the transfer: the first bit received ends up in bit 7 when MSB-first and in bit 0 when LSB-first. After a loopback transfer, rx_byte equals tx_byte.
- R8: done and irq rise together when a transfer ends and stay high until the next accepted start, which clears them on the accepting edge.
- R9: A start that arrives while busy is high has no effect. The running transfer keeps its length, its data and its settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; taken only when idle |
| tx_byte | input | DATA_W | Byte to send, captured at start |
| lsb_first | input | 1 | 1: least significant bit first |
| sample_rise | input | 1 | 1: sample on rising shift-clock edge |
| ext_clk_sel | input | 1 | 1: shift clock taken from sck_in |
| rate_sel | input | 3 | Internal divide-ratio code |
| sck_in | input | 1 | External shift clock |
| ser_in | input | 1 | Serial data in |
| sck_out | output | 1 | Internally generated shift clock, idle high |
| ser_out | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt request |
| rx_byte | output | DATA_W | Received byte |

## Verification
The bench uses the default parameters: DATA_W of 8 and SYNC_STAGES of 2. With these values even the largest ratio of 512 ends a transfer in 4096 cycles, so every rate code, the two unused ones included, can be timed to the exact cycle and its clock pulses counted. The two-stage synchroniser leaves a delay of about three cycles, which lets a bench-driven external clock with ten-cycle half periods check the sequence on ser_out bit by bit, in both orders and for both sampling edges.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int RATE_W    = 3;
    localparam int MAX_RATIO = 512;
    localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;

    // Settings captured when a transfer is accepted
    typedef struct packed {
        logic lsb_first;
        logic sample_rise;
        logic ext_clk;
    } xfer_cfg_t;

    // One-cycle edge events of a shift clock in the system domain
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_ev_t;

    // Rate code to system-clock divide ratio; unused codes run slowest
    function automatic logic [RATIO_W-1:0] div_ratio(input logic [RATE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = RATIO_W'(512);
            3'd1:    r = RATIO_W'(256);
            3'd2:    r = RATIO_W'(128);
            3'd3:    r = RATIO_W'(32);
            3'd4:    r = RATIO_W'(16);
            3'd5:    r = RATIO_W'(8);
            default: r = RATIO_W'(MAX_RATIO);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [RATE_W-1:0] rate,
    output logic              sck,
    output sck_ev_t           ev,
    output logic              last_rise
);

    localparam int HALF_W = $clog2(MAX_RATIO / 2);
    localparam int TOG_N  = 2 * DATA_W;
    localparam int TOG_W  = $clog2(TOG_N);
    localparam logic [TOG_W-1:0] TOG_LAST = TOG_W'(TOG_N - 1);

    logic                 run;
    logic [HALF_W-1:0]    half_cnt;
    logic [HALF_W-1:0]    half_lim;
    logic [TOG_W-1:0]     tog_cnt;
    logic [RATIO_W-1:0]   ratio;
    logic                 tick;

    assign ratio = div_ratio(rate);
    assign tick  = run && (half_cnt == half_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            half_cnt <= '0;
            half_lim <= '0;
            tog_cnt  <= '0;
            sck      <= 1'b1;
        end else if (go) begin
            run      <= 1'b1;
            half_cnt <= '0;
            half_lim <= HALF_W'((ratio >> 1) - RATIO_W'(1));
            tog_cnt  <= '0;
            sck      <= 1'b1;
        end else if (tick) begin
            half_cnt <= '0;
            sck      <= ~sck;
            tog_cnt  <= tog_cnt + TOG_W'(1);
            if (tog_cnt == TOG_LAST) begin
                run <= 1'b0;
            end
        end else if (run) begin
            half_cnt <= half_cnt + HALF_W'(1);
        end
    end

    assign ev.fall   = tick &  sck;
    assign ev.rise   = tick & ~sck;
    assign last_rise = ev.rise && (tog_cnt == TOG_LAST);

endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync
    import sio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_in,
    output sck_ev_t ev
);

    // stages 0..SYNC_STAGES-1 synchronise, the last one holds the previous level
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], sck_in};
        end
    end

    assign ev.rise =  chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign ev.fall = ~chain[SYNC_STAGES-1] &  chain[SYNC_STAGES];

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_lsb,
    input  logic [DATA_W-1:0] load_byte,
    input  xfer_cfg_t         cfg,
    input  sck_ev_t           ev,
    input  logic              int_finish,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] rx_q,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [CNT_W-1:0]  bit_cnt;
    logic              pend_shift;
    logic              sample_ev;
    logic              shift_ev;

    assign sample_ev = cfg.sample_rise ? ev.rise : ev.fall;
    assign shift_ev  = cfg.sample_rise ? ev.fall : ev.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr      <= '0;
            rx_q       <= '0;
            bit_cnt    <= '0;
            pend_shift <= 1'b0;
            ser_out    <= 1'b1;
            busy       <= 1'b0;
            done       <= 1'b0;
        end else if (load) begin
            tx_sr      <= load_byte;
            ser_out    <= load_lsb ? load_byte[0] : load_byte[DATA_W-1];
            rx_q       <= '0;
            bit_cnt    <= '0;
            pend_shift <= 1'b0;
            busy       <= 1'b1;
            done       <= 1'b0;
        end else if (busy) begin
            if (sample_ev) begin
                if (cfg.lsb_first) begin
                    rx_q <= {ser_in, rx_q[DATA_W-1:1]};
                end else begin
                    rx_q <= {rx_q[DATA_W-2:0], ser_in};
                end
                bit_cnt    <= bit_cnt + CNT_W'(1);
                pend_shift <= 1'b1;
                if (cfg.ext_clk && (bit_cnt == LAST_BIT)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (shift_ev && pend_shift) begin
                pend_shift <= 1'b0;
                if (cfg.lsb_first) begin
                    tx_sr   <= tx_sr >> 1;
                    ser_out <= tx_sr[1];
                end else begin
                    tx_sr   <= tx_sr << 1;
                    ser_out <= tx_sr[DATA_W-2];
                end
            end
            if (!cfg.ext_clk && int_finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              lsb_first,
    input  logic              sample_rise,
    input  logic              ext_clk_sel,
    input  logic [2:0]        rate_sel,
    input  logic              sck_in,
    input  logic              ser_in,
    output logic              sck_out,
    output logic              ser_out,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [DATA_W-1:0] rx_byte
);

    xfer_cfg_t cfg_q;
    sck_ev_t   int_ev;
    sck_ev_t   ext_ev;
    sck_ev_t   sel_ev;
    logic      start_ok;
    logic      int_last;
    logic      busy_i;

    assign start_ok = start && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start_ok) begin
            cfg_q.lsb_first   <= lsb_first;
            cfg_q.sample_rise <= sample_rise;
            cfg_q.ext_clk     <= ext_clk_sel;
        end
    end

    sio_clkgen #(.DATA_W(DATA_W)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .go        (start_ok && !ext_clk_sel),
        .rate      (rate_sel),
        .sck       (sck_out),
        .ev        (int_ev),
        .last_rise (int_last)
    );

    sio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sck_in (sck_in),
        .ev     (ext_ev)
    );

    assign sel_ev = cfg_q.ext_clk ? ext_ev : int_ev;

    sio_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (start_ok),
        .load_lsb   (lsb_first),
        .load_byte  (tx_byte),
        .cfg        (cfg_q),
        .ev         (sel_ev),
        .int_finish (int_last),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .rx_q       (rx_byte),
        .busy       (busy_i),
        .done       (done)
    );

    assign busy = busy_i;
    assign irq  = done;

endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ext_clk_sel,
    input logic busy,
    input logic done,
    input logic irq,
    input logic sck_out,
    input logic ser_out
);

    localparam int FC_W = $clog2(DATA_W + 1) + 1;

    logic            int_q;
    logic            sck_d;
    logic [FC_W-1:0] fall_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q    <= 1'b0;
            sck_d    <= 1'b1;
            fall_cnt <= '0;
        end else begin
            sck_d <= sck_out;
            if (start && !busy) begin
                int_q    <= !ext_clk_sel;
                fall_cnt <= '0;
            end else if (sck_d && !sck_out) begin
                fall_cnt <= fall_cnt + FC_W'(1);
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!busy && !done && !irq && sck_out && ser_out)); // R1

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_out); // R3

    AST_EIGHT_PULSES: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && int_q) |-> (fall_cnt == FC_W'(DATA_W))); // R3

    AST_EXT_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy && !int_q) |-> sck_out); // R6

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && irq)); // R8

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done)); // R8

    AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (busy || done)); // R9

endmodule

bind sio_shifter sio_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ext_clk_sel (ext_clk_sel),
    .busy        (busy),
    .done        (done),
    .irq         (irq),
    .sck_out     (sck_out),
    .ser_out     (ser_out)
);

// File: tb/test_sio_shifter.sv
module test_sio_shifter;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] tx_byte;
    logic       lsb_first;
    logic       sample_rise;
    logic       ext_clk_sel;
    logic [2:0] rate_sel;
    logic       sck_drv;
    logic       sin_drv;
    logic       loop_en;
    logic       ser_in;
    logic       sck_out;
    logic       ser_out;
    logic       busy;
    logic       done;
    logic       irq;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    assign ser_in = loop_en ? ser_out : sin_drv;

    sio_shifter i_sio_shifter (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tx_byte     (tx_byte),
        .lsb_first   (lsb_first),
        .sample_rise (sample_rise),
        .ext_clk_sel (ext_clk_sel),
        .rate_sel    (rate_sel),
        .sck_in      (sck_drv),
        .ser_in      (ser_in),
        .sck_out     (sck_out),
        .ser_out     (ser_out),
        .busy        (busy),
        .done        (done),
        .irq         (irq),
        .rx_byte     (rx_byte)
    );

    typedef struct packed {
        logic [7:0]  tx;
        logic [2:0]  rate;
        logic        lsb;
        logic        srise;
        logic [15:0] cyc;
    } vec_t;

    // internal-clock loopback vectors: busy length is 8 x ratio (R2)
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 3'd5, 1'b0, 1'b0, 16'd64},
        '{8'h3C, 3'd4, 1'b1, 1'b1, 16'd128},
        '{8'h81, 3'd3, 1'b0, 1'b1, 16'd256},
        '{8'h7E, 3'd2, 1'b1, 1'b0, 16'd1024},
        '{8'hFF, 3'd1, 1'b0, 1'b0, 16'd2048},
        '{8'h00, 3'd0, 1'b1, 1'b1, 16'd4096},
        '{8'h96, 3'd6, 1'b0, 1'b0, 16'd4096},
        '{8'h5A, 3'd7, 1'b1, 1'b1, 16'd4096}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Internal transfer with loopback; poke_at>0 pulses start mid-transfer
    task automatic run_internal(input vec_t v, input int poke_at);
        int cyc = 0;
        int falls = 0;
        logic prev;
        @(negedge clk);
        loop_en     = 1'b1;
        ext_clk_sel = 1'b0;
        tx_byte     = v.tx;
        rate_sel    = v.rate;
        lsb_first   = v.lsb;
        sample_rise = v.srise;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && !irq, "R8 done cleared by start", int'(done), 0);
        prev = sck_out;
        while (busy && cyc < 5000) begin
            cyc++;
            if (cyc == poke_at) begin
                start     = 1'b1;
                tx_byte   = 8'h00;
                rate_sel  = 3'd0;
                lsb_first = ~v.lsb;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (prev && !sck_out) falls++;
            prev = sck_out;
        end
        start = 1'b0;
        check(cyc == int'(v.cyc), poke_at > 0 ? "R9 busy length kept" : "R2 busy length", cyc, int'(v.cyc));
        check(falls == 8, "R3 pulse count", falls, 8);
        check(sck_out, "R3 idle high after", int'(sck_out), 1);
        check(rx_byte == v.tx, poke_at > 0 ? "R9 data kept" : "R7 loopback rx", int'(rx_byte), int'(v.tx));
        check(done && irq, "R8 done and irq", int'({done, irq}), 3);
    endtask

    // External-clock transfer driven by the bench
    task automatic run_external(input logic [7:0] tx, input logic [7:0] pat,
                                input logic lsb, input logic srise);
        logic [7:0] cap = '0;
        logic [7:0] exp_seq = '0;
        logic       sck_low_seen = 1'b0;
        @(negedge clk);
        loop_en     = 1'b0;
        ext_clk_sel = 1'b1;
        sck_drv     = 1'b1;
        tx_byte     = tx;
        lsb_first   = lsb;
        sample_rise = srise;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            int idx = lsb ? k : 7 - k;
            if (srise) sck_drv = 1'b0;
            sin_drv = pat[idx];
            repeat (10) @(negedge clk);
            cap[7-k]     = ser_out;
            exp_seq[7-k] = tx[idx];
            if (!sck_out) sck_low_seen = 1'b1;
            sck_drv = srise;
            repeat (10) @(negedge clk);
            if (!srise) sck_drv = 1'b1;
        end
        repeat (5) @(negedge clk);
        check(cap == exp_seq, srise ? "R4 R5 order, rise sample" : "R4 R5 order, fall sample",
              int'(cap), int'(exp_seq));
        check(rx_byte == pat, "R7 rx bit order", int'(rx_byte), int'(pat));
        check(!busy && done && irq, "R6 ends on eighth sample", int'({busy, done, irq}), 3);
        check(!sck_low_seen, "R6 sck_out quiet", int'(sck_low_seen), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; tx_byte = '0; lsb_first = 1'b0;
        sample_rise = 1'b0; ext_clk_sel = 1'b0; rate_sel = '0;
        sck_drv = 1'b1; sin_drv = 1'b0; loop_en = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !irq, "R1 flags in reset", int'({busy, done, irq}), 0);
        check(sck_out && ser_out, "R1 lines in reset", int'({sck_out, ser_out}), 3);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && sck_out, "R1 idle after reset", int'({busy, sck_out}), 1);

        for (int i = 0; i < NV; i++) begin
            run_internal(VECS[i], 0);
        end

        // R9: start while busy, with other data and settings
        run_internal('{8'h6B, 3'd5, 1'b0, 1'b0, 16'd64}, 20);

        // R4 R5 R6 R7: external clock in every order and edge
        run_external(8'hC3, 8'h1D, 1'b0, 1'b0);
        run_external(8'hC3, 8'h1D, 1'b1, 1'b1);
        run_external(8'h01, 8'h80, 1'b1, 1'b0);
        run_external(8'h80, 8'h01, 1'b0, 1'b1);

        summary();
        $finish;
    end

endmodule